// File: doc/BRIEF.md
# Saturating Wiper Position Register

This block holds the tap position of a 64-tap resistor switch array. The position is a 6-bit volatile value that drives two outputs: the value itself, and a one-hot select vector that closes exactly one switch. Position 0 connects the wiper to the low terminal. Position 63 connects it to the high terminal.

A command decoder updates the position with single-cycle strobes. There are four ways to change it:
- a direct write of a serial-received value;
- a parallel copy from one of four stored registers, chosen by a 2-bit pointer;
- single-tap steps up or down;
- a recall of stored register 0 on the first clock after reset is released.

When several sources are active in the same cycle, a fixed priority picks one. Steps stop at the ends of the range instead of wrapping.

Top module: `wiper_pos_reg`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the position is 0. On the first clock edge after release, the position takes the value of stored register 0.
- R2: A write strobe loads the 6-bit write data into the position on the next clock edge.
- R3: A copy strobe loads the stored register selected by the pointer (0 to 3) into the position on the next clock edge.
- R4: A step strobe with direction 1 raises the position by one. With direction 0 it lowers the position by one.
- R5: A step up at 63 leaves the position at 63. A step down at 0 leaves it at 0.
- R6: When strobes coincide, the priority order is recall, then write, then copy, then step.
- R7: The select output has exactly one bit set, and that bit's index equals the position.
- R8: The readback byte is two zero bits followed by the six position bits.
- R9: With no strobe active, the position holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_stb | input | 1 | Direct write strobe |
| wr_data | input | 6 | Direct write value |
| cp_stb | input | 1 | Copy-from-stored strobe |
| cp_sel | input | 2 | Stored register pointer |
| store0 | input | 6 | Stored register 0 |
| store1 | input | 6 | Stored register 1 |
| store2 | input | 6 | Stored register 2 |
| store3 | input | 6 | Stored register 3 |
| step_stb | input | 1 | Single-step strobe |
| step_up | input | 1 | Step direction: 1 toward high, 0 toward low |
| pos | output | 6 | Current position |
| rd_byte | output | 8 | Readback byte |
| tap_sel | output | 64 | One-hot switch select |

## Verification
The hardest case to reach is the recall cycle overlapping with other strobes. The bench drives write, copy and step strobes across the release of reset, so that recall competes with all of them on the same edge. Recall must win. The saturation cases are reached by writing 63 or 0 directly and then issuing steps in the outward direction.

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg #(
  parameter int W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [W-1:0]      wr_data,
  input  logic              cp_stb,
  input  logic [1:0]        cp_sel,
  input  logic [W-1:0]      store0,
  input  logic [W-1:0]      store1,
  input  logic [W-1:0]      store2,
  input  logic [W-1:0]      store3,
  input  logic              step_stb,
  input  logic              step_up,
  output logic [W-1:0]      pos,
  output logic [7:0]        rd_byte,
  output logic [(1<<W)-1:0] tap_sel
);
  localparam int TAPS = 1 << W;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         recall;
  logic [W-1:0] cp_val;
  logic [W-1:0] nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) recall <= 1'b1;
    else        recall <= 1'b0;

  always_comb
    case (cp_sel)
      2'd0:    cp_val = store0;
      2'd1:    cp_val = store1;
      2'd2:    cp_val = store2;
      default: cp_val = store3;
    endcase

  always_comb begin
    nxt = pos;
    if (recall)        nxt = store0;
    else if (wr_stb)   nxt = wr_data;
    else if (cp_stb)   nxt = cp_val;
    else if (step_stb) begin
      if (step_up && pos != TOP)         nxt = pos + 1'b1;
      else if (!step_up && pos != '0)    nxt = pos - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pos <= '0;
    else        pos <= nxt;

  assign rd_byte = 8'({2'b00, pos});

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap_sel[i] = (pos == W'(i));
  end

  AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1 && tap_sel[pos]); // R7
  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!recall && !wr_stb && !cp_stb && step_stb && step_up && pos == TOP) |=> pos == TOP); // R5
  AST_NO_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (!recall && !wr_stb && !cp_stb && step_stb && !step_up && pos == '0) |=> pos == '0); // R5
  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!recall && wr_stb) |=> pos == $past(wr_data)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!recall && !wr_stb && !cp_stb && !step_stb) |=> $stable(pos)); // R9
  AST_RD_TOP0: assert property (@(posedge clk) disable iff (!rst_n)
    rd_byte[7:6] == 2'b00); // R8
endmodule

// File: tb/wiper_pos_reg_bench.sv
module wiper_pos_reg_bench;
  localparam time CLK_P = 10;
  logic clk = 0, rst_n = 0;
  logic wr_stb = 0, cp_stb = 0, step_stb = 0, step_up = 0;
  logic [5:0] wr_data = 0;
  logic [1:0] cp_sel = 0;
  logic [5:0] store0 = 6'h15, store1 = 6'h2A, store2 = 6'h07, store3 = 6'h38;
  logic [5:0] pos;
  logic [7:0] rd_byte;
  logic [63:0] tap_sel;
  int errs = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  wiper_pos_reg u_wiper_pos_reg (.clk, .rst_n, .wr_stb, .wr_data, .cp_stb, .cp_sel,
    .store0, .store1, .store2, .store3, .step_stb, .step_up, .pos, .rd_byte, .tap_sel);

  task automatic chk(string req, logic [5:0] exp);
    checks++;
    if (pos !== exp || tap_sel !== (64'd1 << exp) || rd_byte !== {2'b00, exp}) begin
      errs++;
      $display("FAIL %s pos=%h rd=%h sel=%h expected pos=%h", req, pos, rd_byte, tap_sel, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #(CLK_P/4);
  endtask

  task automatic idle();
    wr_stb = 0; cp_stb = 0; step_stb = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; idle(); wr_stb = 1; wr_data = 6'h3C; cp_stb = 1; cp_sel = 2; step_stb = 1; step_up = 1;
    tick(); chk("R1 in reset", 6'h00);
    #(CLK_P/4) rst_n = 1;
    #1 chk("R1 before first edge", 6'h00);
    tick(); chk("R1/R6 recall wins", 6'h15);
    idle();
  endtask

  task automatic t_write();
    wr_stb = 1; wr_data = 6'h2B; tick(); chk("R2 write", 6'h2B);
    wr_data = 6'h3F; tick(); chk("R2 write top", 6'h3F);
    idle(); tick(); tick(); chk("R9 hold", 6'h3F);
  endtask

  task automatic t_copy();
    logic [5:0] s [4];
    s[0] = store0; s[1] = store1; s[2] = store2; s[3] = store3;
    for (int i = 0; i < 4; i++) begin
      cp_stb = 1; cp_sel = 2'(i); tick(); chk("R3 copy", s[i]);
    end
    idle();
  endtask

  task automatic t_step();
    wr_stb = 1; wr_data = 6'h10; tick(); idle();
    step_stb = 1; step_up = 1; tick(); chk("R4 up", 6'h11);
    tick(); chk("R4 up2", 6'h12);
    step_up = 0; tick(); tick(); tick(); chk("R4 down", 6'h0F);
    idle();
  endtask

  task automatic t_sat();
    wr_stb = 1; wr_data = 6'h3F; tick(); idle();
    step_stb = 1; step_up = 1; tick(); tick(); chk("R5 top", 6'h3F);
    idle(); wr_stb = 1; wr_data = 6'h00; tick(); idle();
    step_stb = 1; step_up = 0; tick(); tick(); chk("R5 bottom", 6'h00);
    step_up = 1; tick(); chk("R5 leave bottom", 6'h01);
    idle();
  endtask

  task automatic t_prio();
    wr_stb = 1; wr_data = 6'h05; cp_stb = 1; cp_sel = 3; step_stb = 1; step_up = 1;
    tick(); chk("R6 write over copy", 6'h05);
    wr_stb = 0; tick(); chk("R6 copy over step", 6'h38);
    cp_stb = 0; tick(); chk("R6 step alone", 6'h39);
    idle();
  endtask

  task automatic t_sweep();
    for (int v = 0; v < 64; v++) begin
      wr_stb = 1; wr_data = 6'(v); tick(); chk("R7/R8 sweep", 6'(v));
    end
    idle();
  endtask

  initial begin
    fork
      begin
        t_reset(); t_write(); t_copy(); t_step(); t_sat(); t_prio(); t_sweep();
      end
      begin
        #(CLK_P*100000); errs++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule